// File: doc/BRIEF.md
# Mailbox Transmit Abort Controller

This block holds the 4-bit CODE field of each message buffer (mailbox) in a small CAN-style transmit array. It decides what a host write of the abort code does to each mailbox. The host writes and reads CODE values through a simple register port. A transmit engine tells the block when it begins sending a mailbox and when that frame ends, either sent or lost (lost arbitration or an error).

A write to a mailbox that has not begun transmitting always takes effect. Writing the abort code there only deactivates the mailbox: CODE changes at once and no interrupt flag is raised. Once transmission has begun, host writes to CODE are blocked. If aborting is enabled and the blocked value is the abort code, the request is held pending. When the frame ends, the mailbox either shows sent or shows aborted, and its interrupt flag is set. The host clears flags by writing 1 to them.

Top module: `mbx_abort_ctrl`

## Requirements
- R1: After reset every CODE reads 4'b0000, and all busy, pending and interrupt flag bits are 0.
- R2: A host write to a mailbox that is not busy loads the written CODE, readable on the next cycle, and sets no interrupt flag.
- R3: A start request makes the mailbox busy only if its CODE is 4'b1100. A start for any other CODE is ignored. A start and a host write to the same idle mailbox in the same cycle: the write takes effect and the start is dropped.
- R4: Writing the abort code 4'b1001 to a mailbox that is not busy deactivates it. CODE reads 1001, no flag is set, nothing is pending, and a later start is ignored.
- R5: While a mailbox is busy, a host write leaves its CODE unchanged, whatever value is written.
- R6: With abort enable set, writing 1001 to a busy mailbox sets its pending bit. If the frame then ends lost, CODE becomes 1001, the flag is set, and busy and pending clear.
- R7: A frame that ends sent sets CODE to 4'b1000 and sets the flag, even if an abort is pending. Busy and pending clear.
- R8: A frame that ends lost with no abort pending clears busy, leaves CODE at 1100 and sets no flag.
- R9: With abort enable clear, a write of 1001 to a busy mailbox queues nothing. The pending bit stays 0.
- R10: Interrupt flags are write-1-to-clear. A flag being set wins over a clear of the same bit in the same cycle. Other mailboxes' flags are untouched.
- R11: A frame-end report for a mailbox that is not busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| abort_en_i | input | 1 | Enables pending aborts of busy mailboxes |
| wr_en_i | input | 1 | Host CODE write strobe |
| wr_idx_i | input | IDX_W | Mailbox written |
| wr_code_i | input | 4 | CODE value written |
| rd_idx_i | input | IDX_W | Mailbox read back |
| rd_code_o | output | 4 | CODE of mailbox rd_idx_i |
| flag_clr_i | input | NUM_MB | Write-1-to-clear mask for interrupt flags |
| tx_start_i | input | 1 | Engine begins transmitting tx_idx_i |
| tx_done_i | input | 1 | Frame of tx_idx_i has ended |
| tx_ok_i | input | 1 | With tx_done_i: 1 sent, 0 lost or error |
| tx_idx_i | input | IDX_W | Mailbox addressed by the engine |
| tx_busy_o | output | NUM_MB | Transmission started, frame not yet ended |
| abort_pend_o | output | NUM_MB | Abort request held pending |
| iflag_o | output | NUM_MB | Per-mailbox interrupt flags |

## Verification
The hardest situation to reach is an abort that lands between the start of a frame and its end. In that window the write must be blocked and remembered, and how the frame ends then picks the final CODE. The bench reaches it by loading 1100, issuing a start, and only then writing 1001. It does this with abort enable both set and clear, and ends the frame both sent and lost. Each mailbox is swept in turn. The same-cycle clash of a write and a start, and of a flag set and its clear, are driven on purpose in single cycles.

// File: rtl/mbx_abort_pkg.sv
package mbx_abort_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_IDLE  = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_SENT  = 4'b1000;
  localparam logic [CODE_W-1:0] CODE_ABORT = 4'b1001;
  localparam logic [CODE_W-1:0] CODE_REQ   = 4'b1100;
endpackage

// File: rtl/mbx_dec.sv
module mbx_dec #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [N-1:0]     hot_o
);
  for (genvar g = 0; g < N; g++) begin : g_hot
    assign hot_o[g] = en_i && (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/mbx_rd_mux.sv
module mbx_rd_mux #(
  parameter int N     = 4,
  parameter int W     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0][W-1:0] data_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [W-1:0]        data_o
);
  always_comb begin
    data_o = '0;
    for (int k = 0; k < N; k++)
      if (idx_i == IDX_W'(k)) data_o = data_i[k];
  end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_abort_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_en_i,
  input  logic              wr_hit_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              start_hit_i,
  input  logic              done_hit_i,
  input  logic              done_ok_i,
  input  logic              flag_clr_i,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o,
  output logic              pend_o,
  output logic              flag_o
);
  logic [CODE_W-1:0] code_q;
  logic busy_q, pend_q, flag_q, flag_set;

  // frame end resolves a busy slot; otherwise writes beat starts
  assign flag_set = done_hit_i && busy_q && (done_ok_i || pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= CODE_IDLE;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (done_hit_i && busy_q) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      if (done_ok_i)   code_q <= CODE_SENT;
      else if (pend_q) code_q <= CODE_ABORT;
    end else if (wr_hit_i && !busy_q) begin
      code_q <= wr_code_i;
    end else if (wr_hit_i && busy_q) begin
      if (abort_en_i && (wr_code_i == CODE_ABORT)) pend_q <= 1'b1;
    end else if (start_hit_i && (code_q == CODE_REQ)) begin
      busy_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_set || (flag_q && !flag_clr_i);
  end

  assign code_o = code_q;
  assign busy_o = busy_q;
  assign pend_o = pend_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/mbx_abort_ctrl.sv
module mbx_abort_ctrl
  import mbx_abort_pkg::*;
#(
  parameter int NUM_MB = 4,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_en_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [CODE_W-1:0] rd_code_o,
  input  logic [NUM_MB-1:0] flag_clr_i,
  input  logic              tx_start_i,
  input  logic              tx_done_i,
  input  logic              tx_ok_i,
  input  logic [IDX_W-1:0]  tx_idx_i,
  output logic [NUM_MB-1:0] tx_busy_o,
  output logic [NUM_MB-1:0] abort_pend_o,
  output logic [NUM_MB-1:0] iflag_o
);
  logic [NUM_MB-1:0] wr_hit, start_hit, done_hit;
  logic [NUM_MB-1:0][CODE_W-1:0] mb_code;

  mbx_dec #(.N(NUM_MB), .IDX_W(IDX_W)) u_wr_dec (
    .en_i(wr_en_i), .idx_i(wr_idx_i), .hot_o(wr_hit));
  mbx_dec #(.N(NUM_MB), .IDX_W(IDX_W)) u_st_dec (
    .en_i(tx_start_i), .idx_i(tx_idx_i), .hot_o(start_hit));
  mbx_dec #(.N(NUM_MB), .IDX_W(IDX_W)) u_dn_dec (
    .en_i(tx_done_i), .idx_i(tx_idx_i), .hot_o(done_hit));

  for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
    mbx_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .abort_en_i (abort_en_i),
      .wr_hit_i   (wr_hit[g]),
      .wr_code_i  (wr_code_i),
      .start_hit_i(start_hit[g]),
      .done_hit_i (done_hit[g]),
      .done_ok_i  (tx_ok_i),
      .flag_clr_i (flag_clr_i[g]),
      .code_o     (mb_code[g]),
      .busy_o     (tx_busy_o[g]),
      .pend_o     (abort_pend_o[g]),
      .flag_o     (iflag_o[g])
    );
  end

  mbx_rd_mux #(.N(NUM_MB), .W(CODE_W), .IDX_W(IDX_W)) u_rd_mux (
    .data_i(mb_code), .idx_i(rd_idx_i), .data_o(rd_code_o));
endmodule

// File: rtl/mbx_abort_ctrl_chk.sv
module mbx_abort_ctrl_chk
  import mbx_abort_pkg::*;
#(
  parameter int NUM_MB = 4,
  parameter int IDX_W  = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          abort_en_i,
  input logic                          tx_done_i,
  input logic                          tx_ok_i,
  input logic [IDX_W-1:0]              tx_idx_i,
  input logic [NUM_MB-1:0]             tx_busy_o,
  input logic [NUM_MB-1:0]             abort_pend_o,
  input logic [NUM_MB-1:0]             iflag_o,
  input logic [NUM_MB-1:0][CODE_W-1:0] mb_code
);
  for (genvar g = 0; g < NUM_MB; g++) begin : g_chk
    AST_BLOCKED_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_busy_o[g] && !(tx_done_i && tx_idx_i == IDX_W'(g))) |=> $stable(mb_code[g])); // R5
    AST_FLAG_FROM_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(iflag_o[g]) |-> $past(tx_busy_o[g] && tx_done_i && tx_idx_i == IDX_W'(g))); // R6
    AST_FLAG_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(iflag_o[g]) |-> (mb_code[g] == ($past(tx_ok_i) ? CODE_SENT : CODE_ABORT))); // R7
    AST_ABORT_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(iflag_o[g]) && mb_code[g] == CODE_ABORT) |-> $past(abort_pend_o[g])); // R6
    AST_PEND_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(abort_pend_o[g]) |-> $past(abort_en_i)); // R9
    AST_PEND_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_pend_o[g] |-> tx_busy_o[g]); // R6
  end
endmodule

bind mbx_abort_ctrl mbx_abort_ctrl_chk #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .abort_en_i(abort_en_i), .tx_done_i(tx_done_i),
  .tx_ok_i(tx_ok_i), .tx_idx_i(tx_idx_i), .tx_busy_o(tx_busy_o),
  .abort_pend_o(abort_pend_o), .iflag_o(iflag_o), .mb_code(mb_code));

// File: tb/mbx_abort_ctrl_test.sv
`timescale 1ns/1ps
module mbx_abort_ctrl_test;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic abort_en_i = 1'b0, wr_en_i = 1'b0, tx_start_i = 1'b0, tx_done_i = 1'b0, tx_ok_i = 1'b0;
  logic [IW-1:0] wr_idx_i = '0, rd_idx_i = '0, tx_idx_i = '0;
  logic [3:0] wr_code_i = '0, rd_code_o;
  logic [N-1:0] flag_clr_i = '0, tx_busy_o, abort_pend_o, iflag_o;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  mbx_abort_ctrl #(.NUM_MB(N)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 0; tx_start_i = 0; tx_done_i = 0; tx_ok_i = 0; flag_clr_i = '0;
  endtask

  task automatic hwr(input int m, input logic [3:0] c);
    wr_en_i = 1; wr_idx_i = IW'(m); wr_code_i = c; tick();
  endtask

  task automatic start(input int m);
    tx_start_i = 1; tx_idx_i = IW'(m); tick();
  endtask

  task automatic fin(input int m, input logic ok);
    tx_done_i = 1; tx_ok_i = ok; tx_idx_i = IW'(m); tick();
  endtask

  task automatic code_is(input string req, input int m, input logic [3:0] exp);
    rd_idx_i = IW'(m); #1; chk(req, 32'(rd_code_o), 32'(exp));
  endtask

  task automatic state_is(input string req, input logic [N-1:0] busy, input logic [N-1:0] pend,
                          input logic [N-1:0] flg);
    chk({req, " busy"}, 32'(tx_busy_o), 32'(busy));
    chk({req, " pend"}, 32'(abort_pend_o), 32'(pend));
    chk({req, " flag"}, 32'(iflag_o), 32'(flg));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    for (int m = 0; m < N; m++) code_is("R1 reset code", m, 4'b0000);
    state_is("R1 reset", '0, '0, '0);
    rst_ni = 1;
    @(negedge clk_i);

    for (int m = 0; m < N; m++) begin
      logic [N-1:0] oh;
      oh = N'(1) << m;
      // R2: every code value lands on an idle mailbox, no flag
      for (int c = 0; c < 16; c++) begin
        hwr(m, 4'(c));
        code_is("R2 idle write", m, 4'(c));
        chk("R2 no flag", 32'(iflag_o), 0);
      end
      // R3: start ignored unless CODE is 1100
      hwr(m, 4'b0000); start(m);
      state_is("R3 start ignored", '0, '0, '0);
      hwr(m, 4'b1100); start(m);
      state_is("R3 start taken", oh, '0, '0);
      // R5/R9: writes blocked while busy, nothing queued with enable clear
      abort_en_i = 0;
      for (int c = 0; c < 16; c++) begin
        hwr(m, 4'(c));
        code_is("R5 blocked write", m, 4'b1100);
      end
      state_is("R9 no queue when disabled", oh, '0, '0);
      // R8: lost frame without abort
      fin(m, 0);
      code_is("R8 retry code", m, 4'b1100);
      state_is("R8 lost no flag", '0, '0, '0);
      // R11: end report on idle mailbox ignored
      fin(m, 1);
      code_is("R11 idle end ignored", m, 4'b1100);
      state_is("R11 idle end", '0, '0, '0);
      // R6: abort during transmission, frame lost
      abort_en_i = 1;
      start(m); hwr(m, 4'b1001);
      code_is("R6 write blocked", m, 4'b1100);
      state_is("R6 pending", oh, oh, '0);
      fin(m, 0);
      code_is("R6 aborted code", m, 4'b1001);
      state_is("R6 aborted", '0, '0, oh);
      flag_clr_i = ~oh; tick();
      state_is("R10 other clear no effect", '0, '0, oh);
      flag_clr_i = oh; tick();
      state_is("R10 w1c", '0, '0, '0);
      // R7: abort pending but frame sent
      hwr(m, 4'b1100); start(m); hwr(m, 4'b1001);
      state_is("R7 pending", oh, oh, '0);
      fin(m, 1);
      code_is("R7 sent code", m, 4'b1000);
      state_is("R7 sent", '0, '0, oh);
      // R10: set wins over same-cycle clear
      hwr(m, 4'b1100); start(m);
      tx_done_i = 1; tx_ok_i = 1; tx_idx_i = IW'(m); flag_clr_i = oh; tick();
      state_is("R10 set beats clear", '0, '0, oh);
      flag_clr_i = oh; tick();
      state_is("R10 cleared", '0, '0, '0);
      // R4: early abort deactivates, start then ignored
      hwr(m, 4'b1100); hwr(m, 4'b1001);
      code_is("R4 deactivated code", m, 4'b1001);
      state_is("R4 no flag", '0, '0, '0);
      start(m);
      state_is("R4 start ignored", '0, '0, '0);
      // R3: write and start same cycle, write wins
      hwr(m, 4'b1100);
      wr_en_i = 1; wr_idx_i = IW'(m); wr_code_i = 4'b1001; tx_start_i = 1; tx_idx_i = IW'(m);
      tick();
      code_is("R3 write beats start", m, 4'b1001);
      state_is("R3 start dropped", '0, '0, '0);
      abort_en_i = 0;
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule